// File: doc/BRIEF.md
# Power mode and clock controller

This block is the small power and clocking control unit of a microcontroller. It holds a configuration of an idle-enable bit, a keep-clock-in-idle bit, a high-speed select bit and a three-bit divider code. It turns a halt request from the CPU into one of three low-power modes, and it returns to run mode on a wake-up event. It also decides which clock source feeds the system: the undivided high-speed clock, a divided high-speed clock, or the low-speed sub clock.

The high-speed oscillator is modelled as an enable output. The block drives it off in the deep modes, and off whenever the sub clock is the selected source. Each time the enable rises, a settle counter runs and then raises a ready flag. The length of that count depends on whether the oscillator is a crystal or an internal RC type. Whenever the high-speed oscillator feeds the system, the CPU and system clock enables are held off until the flag is high.

Top module: `pwr_clk_ctl`

## Requirements
- R1: After reset the mode is run (`pwr_mode_o` = 0), the idle-enable and keep-clock bits are 0, the undivided high-speed clock is selected (`clk_sel_o` = 0), the oscillator enable is 1 and the ready flag is 0.
- R2: With `osc_rc_i` = 0 (crystal), the ready flag rises on exactly the XTAL_SETTLE-th (default 512) rising edge at which the oscillator enable is high, and not before.
- R3: With `osc_rc_i` = 1 (internal RC), the ready flag rises on exactly the RC_SETTLE-th (default 16) such edge.
- R4: A halt in run mode with idle-enable 0 enters SLEEP (`pwr_mode_o` = 1) on the next edge. In SLEEP the CPU clock enable, system clock enable, oscillator enable and ready flag are all 0.
- R5: A halt in run mode with idle-enable 1 and keep-clock 1 enters IDLE1 (`pwr_mode_o` = 3). There the CPU clock enable is 0, while the system clock enable, oscillator enable and ready flag keep their run-mode values.
- R6: A halt in run mode with idle-enable 1 and keep-clock 0 enters IDLE0 (`pwr_mode_o` = 2). In IDLE0 the CPU clock enable, system clock enable, oscillator enable and ready flag are all 0.
- R7: A wake-up in any low-power mode returns the block to run mode on the next edge. While the high-speed oscillator feeds the system and the ready flag is 0, the CPU and system clock enables stay 0.
- R8: `clk_sel_o` is 0 when the high-speed select bit is 1. Otherwise, divider codes 0 to 5 give `clk_sel_o` = code+1, meaning divide by 2^(code+1), and codes 6 and 7 give `clk_sel_o` = 7, the sub clock.
- R9: When the sub clock is selected, the oscillator enable and the ready flag are 0 and the CPU clock enable is 1 in run mode, with no wait.
- R10: A wake-up in run mode and a halt in any low-power mode have no effect on the mode.
- R11: A pulse on `mode_wr_i` loads high-speed select from bit 0, idle-enable from bit 1 and the divider code from bits 4:2 of `mode_wdata_i`. A pulse on `ctrl_wr_i` loads keep-clock from `ctrl_wdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_i | input | 1 | Halt request from the CPU |
| wake_i | input | 1 | Enabled wake-up event |
| osc_rc_i | input | 1 | Oscillator type: 1 internal RC, 0 crystal |
| mode_wr_i | input | 1 | Write strobe for the mode register |
| mode_wdata_i | input | 5 | Mode register data: divider code, idle-enable, high-speed select |
| ctrl_wr_i | input | 1 | Write strobe for the keep-clock bit |
| ctrl_wdata_i | input | 1 | Keep-clock-in-idle value |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| hs_osc_en_o | output | 1 | High-speed oscillator enable |
| clk_sel_o | output | 3 | Clock mux select |
| hs_ready_o | output | 1 | High-speed oscillator ready flag |
| pwr_mode_o | output | 2 | Current mode: 0 run, 1 SLEEP, 2 IDLE0, 3 IDLE1 |

## Verification
A wrong mode register shows at once on `pwr_mode_o` and on the three enables, one edge after the halt or wake that caused it. A settle counter that is off by even one edge moves the rise of the ready flag and of the CPU clock enable by that edge. The bench therefore samples both flags on the edge before the expected rise as well as on the edge of the rise, after reset and after each wake. A bad source decode appears on `clk_sel_o` and on the oscillator enable in the cycle after the register write.

// File: rtl/pwr_clk_ctl.sv
module pwr_clk_ctl #(
  parameter int XTAL_SETTLE = 512,
  parameter int RC_SETTLE   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_i,
  input  logic       wake_i,
  input  logic       osc_rc_i,
  input  logic       mode_wr_i,
  input  logic [4:0] mode_wdata_i,
  input  logic       ctrl_wr_i,
  input  logic       ctrl_wdata_i,
  output logic       cpu_clk_en_o,
  output logic       sys_clk_en_o,
  output logic       hs_osc_en_o,
  output logic [2:0] clk_sel_o,
  output logic       hs_ready_o,
  output logic [1:0] pwr_mode_o
);

  localparam int MAXS = (XTAL_SETTLE > RC_SETTLE) ? XTAL_SETTLE : RC_SETTLE;
  localparam int LW   = $clog2(MAXS + 1);

  typedef enum logic [1:0] {
    M_RUN   = 2'd0,
    M_SLEEP = 2'd1,
    M_IDLE0 = 2'd2,
    M_IDLE1 = 2'd3
  } mode_e;

  mode_e         mode_q;
  logic          hs_sel_q, idle_en_q, keep_clk_q;
  logic [2:0]    div_q;
  logic [LW-1:0] cnt_q, lim;
  logic          rdy_q;
  logic          use_hs, osc_on, clk_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_sel_q   <= 1'b1;
      idle_en_q  <= 1'b0;
      div_q      <= 3'd0;
      keep_clk_q <= 1'b0;
    end else begin
      if (mode_wr_i) begin
        hs_sel_q  <= mode_wdata_i[0];
        idle_en_q <= mode_wdata_i[1];
        div_q     <= mode_wdata_i[4:2];
      end
      if (ctrl_wr_i)
        keep_clk_q <= ctrl_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= M_RUN;
    else if (mode_q == M_RUN) begin
      if (halt_i)
        mode_q <= !idle_en_q ? M_SLEEP : (keep_clk_q ? M_IDLE1 : M_IDLE0);
    end else if (wake_i)
      mode_q <= M_RUN;
  end

  assign use_hs = hs_sel_q || (div_q < 3'd6);
  assign osc_on = use_hs && (mode_q == M_RUN || mode_q == M_IDLE1);
  assign lim    = osc_rc_i ? LW'(RC_SETTLE) : LW'(XTAL_SETTLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!osc_on) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == lim - LW'(1))
        rdy_q <= 1'b1;
      else
        cnt_q <= cnt_q + LW'(1);
    end
  end

  assign clk_ok       = !use_hs || rdy_q;
  assign hs_osc_en_o  = osc_on;
  assign hs_ready_o   = rdy_q && osc_on;
  assign cpu_clk_en_o = (mode_q == M_RUN) && clk_ok;
  assign sys_clk_en_o = (mode_q == M_RUN || mode_q == M_IDLE1) && clk_ok;
  assign clk_sel_o    = hs_sel_q ? 3'd0 : ((div_q >= 3'd6) ? 3'd7 : div_q + 3'd1);
  assign pwr_mode_o   = mode_q;

  AST_HALT_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && halt_i && !idle_en_q) |=> (pwr_mode_o == 2'd1)); // R4
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode_o == 2'd1) |-> (!sys_clk_en_o && !hs_osc_en_o && !hs_ready_o)); // R4
  AST_IDLE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode_o == 2'd2) |-> (!sys_clk_en_o && !hs_ready_o)); // R6
  AST_CPU_RUN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en_o |-> (pwr_mode_o == 2'd0)); // R5
  AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (use_hs && !hs_ready_o) |-> (!cpu_clk_en_o && !sys_clk_en_o)); // R7
  AST_WAKE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_RUN && wake_i) |=> (pwr_mode_o == 2'd0)); // R7
  AST_SUB_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_o == 3'd7) |-> (!hs_osc_en_o && !hs_ready_o)); // R9
  AST_READY_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> $past(osc_on)); // R2
  AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_RUN && !wake_i) |=> $stable(pwr_mode_o)); // R10

endmodule

// File: tb/pwr_clk_ctl_tb_top.sv
module pwr_clk_ctl_tb_top;
  localparam int XS = 512;
  localparam int RS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_i = 1'b0, wake_i = 1'b0, osc_rc_i = 1'b0;
  logic       mode_wr_i = 1'b0, ctrl_wr_i = 1'b0, ctrl_wdata_i = 1'b0;
  logic [4:0] mode_wdata_i = '0;
  logic       cpu_clk_en_o, sys_clk_en_o, hs_osc_en_o, hs_ready_o;
  logic [2:0] clk_sel_o;
  logic [1:0] pwr_mode_o;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_clk_ctl #(.XTAL_SETTLE(XS), .RC_SETTLE(RS)) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .wake_i(wake_i), .osc_rc_i(osc_rc_i),
    .mode_wr_i(mode_wr_i), .mode_wdata_i(mode_wdata_i), .ctrl_wr_i(ctrl_wr_i),
    .ctrl_wdata_i(ctrl_wdata_i), .cpu_clk_en_o(cpu_clk_en_o), .sys_clk_en_o(sys_clk_en_o),
    .hs_osc_en_o(hs_osc_en_o), .clk_sel_o(clk_sel_o), .hs_ready_o(hs_ready_o),
    .pwr_mode_o(pwr_mode_o));

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_halt();
    halt_i = 1'b1; tick(1); halt_i = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_i = 1'b1; tick(1); wake_i = 1'b0;
  endtask

  task automatic wr_mode(logic [4:0] d);
    mode_wdata_i = d; mode_wr_i = 1'b1; tick(1); mode_wr_i = 1'b0;
  endtask

  task automatic wr_ctrl(logic d);
    ctrl_wdata_i = d; ctrl_wr_i = 1'b1; tick(1); ctrl_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", pwr_mode_o, 0);
    chk("R1 clk_sel", clk_sel_o, 0);
    chk("R1 osc_en", hs_osc_en_o, 1);
    chk("R1 ready", hs_ready_o, 0);
    chk("R7 cpu held", cpu_clk_en_o, 0);
  endtask

  task automatic t_xtal_ready();
    tick(XS - 1);
    chk("R2 ready early", hs_ready_o, 0);
    tick(1);
    chk("R2 ready", hs_ready_o, 1);
    chk("R2 cpu on", cpu_clk_en_o, 1);
    chk("R2 sys on", sys_clk_en_o, 1);
  endtask

  task automatic t_sleep_rc_wake();
    pulse_halt();
    chk("R4 mode", pwr_mode_o, 1);
    chk("R4 cpu", cpu_clk_en_o, 0);
    chk("R4 sys", sys_clk_en_o, 0);
    chk("R4 osc", hs_osc_en_o, 0);
    chk("R4 ready", hs_ready_o, 0);
    pulse_halt();
    chk("R10 halt in sleep", pwr_mode_o, 1);
    osc_rc_i = 1'b1;
    tick(1);
    pulse_wake();
    chk("R7 wake mode", pwr_mode_o, 0);
    chk("R7 cpu held", cpu_clk_en_o, 0);
    chk("R7 osc on", hs_osc_en_o, 1);
    tick(RS - 1);
    chk("R3 ready early", hs_ready_o, 0);
    tick(1);
    chk("R3 ready", hs_ready_o, 1);
    chk("R7 cpu after ready", cpu_clk_en_o, 1);
  endtask

  task automatic t_idle0();
    wr_mode(5'b000_1_1);
    wr_ctrl(1'b0);
    pulse_halt();
    chk("R6 mode", pwr_mode_o, 2);
    chk("R6 cpu", cpu_clk_en_o, 0);
    chk("R6 sys", sys_clk_en_o, 0);
    chk("R6 osc", hs_osc_en_o, 0);
    chk("R6 ready", hs_ready_o, 0);
    pulse_wake();
    chk("R7 wake from idle0", pwr_mode_o, 0);
    tick(RS);
    chk("R3 ready after idle0", hs_ready_o, 1);
  endtask

  task automatic t_idle1();
    wr_ctrl(1'b1);
    pulse_halt();
    chk("R5 mode", pwr_mode_o, 3);
    chk("R5 cpu", cpu_clk_en_o, 0);
    chk("R5 sys", sys_clk_en_o, 1);
    chk("R5 osc", hs_osc_en_o, 1);
    chk("R5 ready", hs_ready_o, 1);
    pulse_wake();
    chk("R7 wake from idle1", pwr_mode_o, 0);
    chk("R7 cpu no wait", cpu_clk_en_o, 1);
    pulse_wake();
    chk("R10 wake in run", pwr_mode_o, 0);
  endtask

  task automatic t_clk_sel();
    for (int c = 0; c < 6; c++) begin
      wr_mode({c[2:0], 2'b10});
      chk("R8 div sel", clk_sel_o, c + 1);
      chk("R11 osc div", hs_osc_en_o, 1);
    end
    for (int c = 6; c < 8; c++) begin
      wr_mode({c[2:0], 2'b10});
      chk("R8 sub sel", clk_sel_o, 7);
      chk("R9 osc off", hs_osc_en_o, 0);
      chk("R9 ready off", hs_ready_o, 0);
      chk("R9 cpu on", cpu_clk_en_o, 1);
    end
    wr_mode(5'b000_1_0);
    chk("R9 back osc on", hs_osc_en_o, 1);
    chk("R7 cpu held on switch", cpu_clk_en_o, 0);
    tick(RS - 1);
    chk("R3 ready early switch", hs_ready_o, 0);
    tick(1);
    chk("R3 ready switch", cpu_clk_en_o, 1);
    wr_mode(5'b000_0_1);
    chk("R11 hs sel", clk_sel_o, 0);
    pulse_halt();
    chk("R11 idle bit cleared", pwr_mode_o, 1);
    pulse_wake();
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    t_reset();
    t_xtal_ready();
    t_sleep_rc_wake();
    t_idle0();
    t_idle1();
    t_clk_sel();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule